// File: doc/BRIEF.md
# Paged memory chip-select decoder

This block turns the 16-bit address of an 8-bit microcontroller bus into chip-selects for eight main flash sectors of 16 KB each, four boot-flash segments of 8 KB each, an 8 KB SRAM and a 256-byte control-register window. Program fetches and data accesses are decoded against two separate maps. The program map has a fixed lower half and a paged upper half. The data map holds the SRAM, the register window and the boot flash.

A page register in the window picks which pair of main sectors fills the upper half of program space. A route register sends data writes to the main flash through the program map, so that code can update flash in place. Each main sector has a write-protect input. A write that protection blocks produces no write enable and sets a sticky violation flag. Software reads the protection inputs back through two read-only registers.

Top module: `pmd_cs_decode`

## Requirements
- R1: A program fetch at 0000h–3FFFh asserts main_cs[0] and one at 4000h–7FFFh asserts main_cs[1], whatever the page value.
- R2: With page value p of 0, 1 or 2, a program fetch at 8000h–BFFFh asserts main_cs[2+2p] and one at C000h–FFFFh asserts main_cs[3+2p]. With page value 3, a fetch in 8000h–FFFFh asserts no select.
- R3: A data read, or a data write with routing off, selects as follows. sram_cs covers 0000h–1FFFh. ctrl_cs covers 2000h–20FFh. boot_cs[0..3] cover 8000h, A000h, C000h and E000h, each 8 KB, in ascending order. A program fetch never asserts sram_cs, ctrl_cs or boot_cs.
- R4: At most one of main_cs, boot_cs, sram_cs and ctrl_cs is high at a time. A program fetch takes priority over the data strobes. With no strobe active, no select and no flash_we is asserted.
- R5: A data read at 2100h–7FFFh asserts no select and returns rdata = FFh. A read of SRAM or boot flash returns rdata = 00h from this block.
- R6: The page register is window offset 00h, bits [1:0]. It resets to 0, takes wdata[1:0] on a data write, applies from the next cycle, and reads back on bits [1:0] with the other bits 0.
- R7: The route register is window offset 04h, bit 0, and resets to 0. While it is 1, a data write outside the window asserts no select and raises flash_we[s] for the sector s that the program map gives at that address and current page. A write in the window still reaches the registers.
- R8: flash_we[s] is never high while wp_main[s] is 1.
- R9: Offset 01h reads wp_main[7:0]. Offset 02h reads {4'b0, wp_boot[3:0]}. Writes to these two offsets change nothing.
- R10: The violation flag is offset 03h, bit 0, and resets to 0. A routed write to a protected sector sets it from the next cycle. Writing 1 to bit 0 clears it. Writing 0 leaves it set.
- R11: Window offsets other than 00h–04h read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| prog_fetch | input | 1 | Program-fetch strobe, active high |
| data_rd | input | 1 | Data read strobe, active high |
| data_wr | input | 1 | Data write strobe, active high |
| wdata | input | 8 | Write data for the register window |
| wp_main | input | 8 | Write-protect bit for each main sector |
| wp_boot | input | 4 | Write-protect bit for each boot segment (status only) |
| main_cs | output | 8 | Main flash sector selects |
| boot_cs | output | 4 | Boot flash segment selects |
| sram_cs | output | 1 | SRAM select |
| ctrl_cs | output | 1 | Register window select |
| flash_we | output | 8 | Main sector write enables for routed writes |
| rdata | output | 8 | Read data for window and unmapped reads |

## Verification
The bench fetches at the edges of every sector under each of the four page values. A decoder that mishandles page 3 would wrap to sectors 2/3 or select sector 8, and one that swaps the pair order would show up at 8000h against C000h. It drives a fetch at SRAM and window addresses and a data read at flash addresses, which catches a decoder that mixes the two spaces. It writes to the status offsets and reads them back, and it writes both 0 and 1 to the violation flag. It sends a routed write to protected and unprotected sectors. A design that ignores protection raises flash_we, and one that wires the flag as level instead of sticky loses it on the next idle cycle.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SECT_N = 8;
    localparam int BOOT_N = 4;
    localparam int PAGE_W = 2;
    localparam int PAGE_N = 3;
    localparam int OFF_W  = 8;
    localparam int SECT_W = $clog2(SECT_N);
    localparam int BOOT_W = $clog2(BOOT_N);
    localparam int FIXED_N = 2;

    localparam logic [ADDR_W-OFF_W-1:0] WIN_PAGE = 8'h20;

    localparam logic [OFF_W-1:0] OFF_PAGE  = 8'h00;
    localparam logic [OFF_W-1:0] OFF_WPM   = 8'h01;
    localparam logic [OFF_W-1:0] OFF_WPB   = 8'h02;
    localparam logic [OFF_W-1:0] OFF_VIOL  = 8'h03;
    localparam logic [OFF_W-1:0] OFF_ROUTE = 8'h04;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_FETCH,
        BUS_READ,
        BUS_WRITE
    } bus_op_e;

    typedef struct packed {
        logic              hit;
        logic [SECT_W-1:0] idx;
    } sect_sel_t;

    typedef struct packed {
        logic              sram;
        logic              win;
        logic [BOOT_N-1:0] boot;
        logic              hole;
    } data_sel_t;

    function automatic bus_op_e classify(input logic f, input logic r, input logic w);
        if (f)      return BUS_FETCH;
        else if (w) return BUS_WRITE;
        else if (r) return BUS_READ;
        return BUS_IDLE;
    endfunction

    function automatic sect_sel_t map_prog(input logic [ADDR_W-1:0] a,
                                           input logic [PAGE_W-1:0] pg);
        sect_sel_t s;
        s.hit = 1'b0;
        s.idx = '0;
        if (!a[ADDR_W-1]) begin
            s.hit = 1'b1;
            s.idx = SECT_W'(a[ADDR_W-2]);
        end else if (int'(pg) < PAGE_N) begin
            s.hit = 1'b1;
            s.idx = SECT_W'(FIXED_N + 2 * int'(pg) + int'(a[ADDR_W-2]));
        end
        return s;
    endfunction
endpackage

// File: rtl/pmd_prog_map.sv
module pmd_prog_map
    import pmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output sect_sel_t         sel,
    output logic [SECT_N-1:0] hot
);
    assign sel = map_prog(addr, page);

    for (genvar s = 0; s < SECT_N; s++) begin : g_hot
        assign hot[s] = sel.hit && (sel.idx == SECT_W'(s));
    end
endmodule

// File: rtl/pmd_data_map.sv
module pmd_data_map
    import pmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output data_sel_t         sel
);
    localparam int SEG_LSB = ADDR_W - 1 - BOOT_W;

    assign sel.sram = (addr[ADDR_W-1:SEG_LSB] == '0);
    assign sel.win  = (addr[ADDR_W-1:OFF_W] == WIN_PAGE);

    for (genvar b = 0; b < BOOT_N; b++) begin : g_boot
        assign sel.boot[b] = addr[ADDR_W-1] &&
                             (addr[ADDR_W-2:SEG_LSB] == BOOT_W'(b));
    end

    assign sel.hole = !(sel.sram || sel.win || addr[ADDR_W-1]);
endmodule

// File: rtl/pmd_ctrl_regs.sv
module pmd_ctrl_regs
    import pmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SECT_N-1:0] wp_main,
    input  logic [BOOT_N-1:0] wp_boot,
    input  logic              blocked,
    output logic [PAGE_W-1:0] page,
    output logic              route,
    output logic              viol,
    output logic [DATA_W-1:0] rd_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            route <= 1'b0;
            viol  <= 1'b0;
        end else begin
            if (wr_en && off == OFF_PAGE)  page  <= wdata[PAGE_W-1:0];
            if (wr_en && off == OFF_ROUTE) route <= wdata[0];
            if (blocked)
                viol <= 1'b1;
            else if (wr_en && off == OFF_VIOL && wdata[0])
                viol <= 1'b0;
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (off)
            OFF_PAGE:  rd_val[PAGE_W-1:0] = page;
            OFF_WPM:   rd_val[SECT_N-1:0] = wp_main;
            OFF_WPB:   rd_val[BOOT_N-1:0] = wp_boot;
            OFF_VIOL:  rd_val[0]          = viol;
            OFF_ROUTE: rd_val[0]          = route;
            default:   rd_val             = '0;
        endcase
    end
endmodule

// File: rtl/pmd_cs_decode.sv
module pmd_cs_decode
    import pmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       addr,
    input  logic              prog_fetch,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        wp_main,
    input  logic [3:0]        wp_boot,
    output logic [7:0]        main_cs,
    output logic [3:0]        boot_cs,
    output logic              sram_cs,
    output logic              ctrl_cs,
    output logic [7:0]        flash_we,
    output logic [7:0]        rdata
);
    bus_op_e           op;
    sect_sel_t         psel;
    logic [SECT_N-1:0] phot;
    data_sel_t         dsel;
    logic [PAGE_W-1:0] page_q;
    logic              route_q;
    logic              viol_q;
    logic [DATA_W-1:0] reg_val;
    logic              routed_wr;
    logic              data_sel_en;
    logic              reg_wr;
    logic              blocked;

    assign op = classify(prog_fetch, data_rd, data_wr);

    pmd_prog_map u_prog (
        .addr (addr),
        .page (page_q),
        .sel  (psel),
        .hot  (phot)
    );

    pmd_data_map u_data (
        .addr (addr),
        .sel  (dsel)
    );

    assign routed_wr   = (op == BUS_WRITE) && route_q && !dsel.win;
    assign data_sel_en = ((op == BUS_READ) || (op == BUS_WRITE)) && !routed_wr;
    assign reg_wr      = (op == BUS_WRITE) && dsel.win;
    assign blocked     = routed_wr && psel.hit && wp_main[psel.idx];

    for (genvar s = 0; s < SECT_N; s++) begin : g_sect
        assign main_cs[s]  = (op == BUS_FETCH) && phot[s];
        assign flash_we[s] = routed_wr && phot[s] && !wp_main[s];
    end

    assign boot_cs = data_sel_en ? dsel.boot : '0;
    assign sram_cs = data_sel_en && dsel.sram;
    assign ctrl_cs = data_sel_en && dsel.win;

    pmd_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .off     (addr[OFF_W-1:0]),
        .wdata   (wdata),
        .wp_main (wp_main),
        .wp_boot (wp_boot),
        .blocked (blocked),
        .page    (page_q),
        .route   (route_q),
        .viol    (viol_q),
        .rd_val  (reg_val)
    );

    always_comb begin
        rdata = '0;
        if (op == BUS_READ) begin
            if (dsel.win)       rdata = reg_val;
            else if (dsel.hole) rdata = '1;
        end
    end
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic        prog_fetch,
    input logic        data_rd,
    input logic        data_wr,
    input logic [7:0]  wdata,
    input logic [7:0]  wp_main,
    input logic [7:0]  main_cs,
    input logic [3:0]  boot_cs,
    input logic        sram_cs,
    input logic        ctrl_cs,
    input logic [7:0]  flash_we,
    input logic [1:0]  page,
    input logic        viol
);
    p_one_select_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_cs, boot_cs, sram_cs, ctrl_cs}));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !(prog_fetch || data_rd || data_wr) |->
            ({main_cs, boot_cs, sram_cs, ctrl_cs} == '0 && flash_we == '0));

    p_fetch_prog_only_r3: assert property (@(posedge clk) disable iff (rst)
        prog_fetch |-> (boot_cs == '0 && !sram_cs && !ctrl_cs && flash_we == '0));

    p_protect_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (flash_we & wp_main) == '0);

    p_viol_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(viol) |-> $past(data_wr && !prog_fetch));

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (viol && !(ctrl_cs && data_wr && addr[7:0] == 8'h03 && wdata[0])) |=> viol);

    p_page_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_cs && data_wr && addr[7:0] == 8'h00) |=> $stable(page));
endmodule

bind pmd_cs_decode pmd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .prog_fetch (prog_fetch),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .wdata      (wdata),
    .wp_main    (wp_main),
    .main_cs    (main_cs),
    .boot_cs    (boot_cs),
    .sram_cs    (sram_cs),
    .ctrl_cs    (ctrl_cs),
    .flash_we   (flash_we),
    .page       (page_q),
    .viol       (viol_q)
);

// File: tb/tb_pmd_cs_decode.sv
module tb_pmd_cs_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        prog_fetch = 1'b0;
    logic        data_rd = 1'b0;
    logic        data_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  wp_main = 8'h25;
    logic [3:0]  wp_boot = 4'hA;
    logic [7:0]  main_cs;
    logic [3:0]  boot_cs;
    logic        sram_cs;
    logic        ctrl_cs;
    logic [7:0]  flash_we;
    logic [7:0]  rdata;

    always #2 clk = ~clk;

    pmd_cs_decode dut (
        .clk(clk), .rst(rst), .addr(addr), .prog_fetch(prog_fetch),
        .data_rd(data_rd), .data_wr(data_wr), .wdata(wdata),
        .wp_main(wp_main), .wp_boot(wp_boot), .main_cs(main_cs),
        .boot_cs(boot_cs), .sram_cs(sram_cs), .ctrl_cs(ctrl_cs),
        .flash_we(flash_we), .rdata(rdata)
    );

    typedef struct packed {
        logic [7:0] mcs;
        logic [3:0] bcs;
        logic       scs;
        logic       ccs;
        logic [7:0] we;
        logic [7:0] rd;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    logic [1:0] m_page = 2'd0;
    logic       m_route = 1'b0;
    logic       m_viol = 1'b0;

    function automatic int prog_sector(input logic [15:0] a);
        if (a < 16'h4000) return 0;
        if (a < 16'h8000) return 1;
        if (m_page == 2'd3) return -1;
        return 2 + 2 * int'(m_page) + ((a >= 16'hC000) ? 1 : 0);
    endfunction

    task automatic step(input bit pf, input bit rd, input bit wr,
                        input logic [15:0] a, input logic [7:0] wd, input string tag);
        obs_t e;
        bit   win;
        int   s;
        @(negedge clk);
        prog_fetch = pf; data_rd = rd; data_wr = wr; addr = a; wdata = wd;
        e = '0;
        win = (a >= 16'h2000) && (a <= 16'h20FF);
        s = prog_sector(a);
        if (pf) begin
            if (s >= 0) e.mcs[s] = 1'b1;
        end else if (rd || wr) begin
            if (wr && m_route && !win) begin
                if (s >= 0 && !wp_main[s]) e.we[s] = 1'b1;
            end else begin
                if (a < 16'h2000)       e.scs = 1'b1;
                else if (win)           e.ccs = 1'b1;
                else if (a >= 16'h8000) e.bcs[(a - 16'h8000) / 16'h2000] = 1'b1;
                if (rd && !wr) begin
                    if (win) begin
                        case (a[7:0])
                            8'h00: e.rd = {6'b0, m_page};
                            8'h01: e.rd = wp_main;
                            8'h02: e.rd = {4'b0, wp_boot};
                            8'h03: e.rd = {7'b0, m_viol};
                            8'h04: e.rd = {7'b0, m_route};
                            default: e.rd = 8'h00;
                        endcase
                    end else if (a >= 16'h2100 && a < 16'h8000) begin
                        e.rd = 8'hFF;
                    end
                end
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (!pf && wr) begin
            if (win) begin
                if (a[7:0] == 8'h00) m_page = wd[1:0];
                if (a[7:0] == 8'h04) m_route = wd[0];
                if (a[7:0] == 8'h03 && wd[0]) m_viol = 1'b0;
            end else if (m_route && s >= 0 && wp_main[s]) begin
                m_viol = 1'b1;
            end
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, "R4 idle");
    endtask

    initial begin : monitor
        obs_t  e;
        obs_t  got;
        string t;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = '{mcs: main_cs, bcs: boot_cs, scs: sram_cs, ccs: ctrl_cs,
                        we: flash_we, rd: rdata};
                total++;
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s addr=%h: actual mcs=%b bcs=%b s=%b c=%b we=%b rd=%h expected mcs=%b bcs=%b s=%b c=%b we=%b rd=%h",
                             t, addr, got.mcs, got.bcs, got.scs, got.ccs, got.we, got.rd,
                             e.mcs, e.bcs, e.scs, e.ccs, e.we, e.rd);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 1'b0, 16'h2000, 8'h00, "R6 page reset");
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 flag reset");
        step(1'b0, 1'b1, 1'b0, 16'h2004, 8'h00, "R7 route reset");
        for (int p = 0; p < 4; p++) begin
            step(1'b0, 1'b0, 1'b1, 16'h2000, 8'(p) | 8'hFC, "R6 page write");
            step(1'b0, 1'b1, 1'b0, 16'h2000, 8'h00, "R6 page readback");
            step(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, "R1 low sector0");
            step(1'b1, 1'b0, 1'b0, 16'h3FFF, 8'h00, "R1 top sector0");
            step(1'b1, 1'b0, 1'b0, 16'h4000, 8'h00, "R1 sector1");
            step(1'b1, 1'b0, 1'b0, 16'h8000, 8'h00, "R2 lower paged");
            step(1'b1, 1'b0, 1'b0, 16'hBFFF, 8'h00, "R2 lower paged top");
            step(1'b1, 1'b0, 1'b0, 16'hC000, 8'h00, "R2 upper paged");
            step(1'b1, 1'b0, 1'b0, 16'hFFFF, 8'h00, "R2 upper paged top");
        end
        step(1'b0, 1'b0, 1'b1, 16'h2000, 8'h01, "R6 page to 1");
        step(1'b0, 1'b1, 1'b0, 16'h0000, 8'h00, "R3 sram base");
        step(1'b0, 1'b1, 1'b0, 16'h1FFF, 8'h00, "R3 sram top");
        step(1'b0, 1'b1, 1'b0, 16'h8000, 8'h00, "R3 boot0");
        step(1'b0, 1'b1, 1'b0, 16'hA000, 8'h00, "R3 boot1");
        step(1'b0, 1'b1, 1'b0, 16'hDFFF, 8'h00, "R3 boot2");
        step(1'b0, 1'b1, 1'b0, 16'hE000, 8'h00, "R3 boot3");
        step(1'b0, 1'b0, 1'b1, 16'hA123, 8'h00, "R3 boot write unrouted");
        step(1'b1, 1'b0, 1'b0, 16'h2000, 8'h00, "R3 fetch in window");
        step(1'b1, 1'b1, 1'b0, 16'h1000, 8'h00, "R4 fetch priority");
        step(1'b0, 1'b1, 1'b0, 16'h2100, 8'h00, "R5 hole low");
        step(1'b0, 1'b1, 1'b0, 16'h7FFF, 8'h00, "R5 hole high");
        step(1'b0, 1'b1, 1'b0, 16'h20FF, 8'h00, "R11 unused offset");
        step(1'b0, 1'b1, 1'b0, 16'h2005, 8'h00, "R11 unused offset 05");
        idle();
        step(1'b0, 1'b1, 1'b0, 16'h2001, 8'h00, "R9 main status");
        step(1'b0, 1'b0, 1'b1, 16'h2001, 8'h00, "R9 write main status");
        step(1'b0, 1'b1, 1'b0, 16'h2001, 8'h00, "R9 main status kept");
        step(1'b0, 1'b0, 1'b1, 16'h2002, 8'hFF, "R9 write boot status");
        step(1'b0, 1'b1, 1'b0, 16'h2002, 8'h00, "R9 boot status kept");
        step(1'b0, 1'b0, 1'b1, 16'h2004, 8'h01, "R7 route on");
        step(1'b0, 1'b1, 1'b0, 16'h2004, 8'h00, "R7 route readback");
        step(1'b0, 1'b0, 1'b1, 16'h4000, 8'h00, "R7 write sector1");
        step(1'b0, 1'b0, 1'b1, 16'hC000, 8'h00, "R7 write sector5 page1");
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 flag after block");
        idle();
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 flag sticky");
        step(1'b0, 1'b0, 1'b1, 16'h2003, 8'h00, "R10 write zero");
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 flag still set");
        step(1'b0, 1'b0, 1'b1, 16'h2003, 8'h01, "R10 clear");
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 flag cleared");
        step(1'b0, 1'b0, 1'b1, 16'h8000, 8'h00, "R7 write sector4");
        step(1'b0, 1'b0, 1'b1, 16'h0010, 8'h00, "R8 protected sector0");
        step(1'b0, 1'b1, 1'b0, 16'h0010, 8'h00, "R7 routed read is data");
        step(1'b0, 1'b0, 1'b1, 16'h2000, 8'h00, "R6 page 0 while routed");
        step(1'b0, 1'b0, 1'b1, 16'h8000, 8'h00, "R8 protected sector2");
        step(1'b0, 1'b0, 1'b1, 16'hC000, 8'h00, "R7 write sector3");
        step(1'b0, 1'b0, 1'b1, 16'h2000, 8'h03, "R2 page 3 routed");
        step(1'b0, 1'b0, 1'b1, 16'hF000, 8'h00, "R2 page 3 no sector");
        step(1'b1, 1'b0, 1'b1, 16'h4000, 8'h00, "R4 fetch over write");
        step(1'b0, 1'b1, 1'b0, 16'h2003, 8'h00, "R10 final flag");
        idle();
        idle();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule